// File: doc/BRIEF.md
# Width-Adapting DMA Channel Engine

This block is one transfer channel of an I/O processor. After a launch pulse it copies data from a source address to a destination address while a byte counter counts down. Source and destination each have a bus width of 8 or 16 bits. When the widths differ, the engine packs two byte reads into one word write, or splits one word read into two byte writes. The byte count is the only termination condition the engine supports. When a transfer ends, the engine adds an offset to a task pointer and hands control back to task code by setting the executing flag again.

Memory traffic uses a valid/ready request port. The engine raises `mem_valid` with a stable address, direction, width and write data. It holds all of them until the cycle in which `mem_ready` is high, and that cycle completes the access. Read data on `mem_rdata` is taken in the same cycle. There is no limit on back-pressure: the engine waits as long as `mem_ready` stays low, and its sequence moves only on an accepted access.

Some settings select features this engine does not implement: port mode, source or destination request synchronisation, translation, masked compare, external termination and single-transfer termination. When a transfer reaches one of them, the engine raises a sticky fault and stops until reset.

Top module: `wadma_channel`

## Requirements
- R1: After reset, the status word is 0, and `fault`, `xfer_pend` and `mem_valid` are all low.
- R2: A `launch` pulse is accepted only while status bit 6 is clear and `fault` is low. It loads the address, count and task-pointer registers and sets status bit 6 (transfer active), status bit 2 (executing) and `xfer_pend`. A `launch` pulse at any other time changes nothing.
- R3: The first active cycle after a launch clears status bit 2 and `xfer_pend`.
- R4: While `mem_valid` is high and `mem_ready` is low, the request stays asserted with an unchanged address, direction, width and write data.
- R5: With a 16-bit source, each fetch is a word read (`mem_wide`=1, `mem_write`=0). The source address increases by 2 and the count decreases by 2.
- R6: With an 8-bit source and a 16-bit destination, byte reads are packed into a word. A byte read at an even count becomes the low half and clears the high half. A byte read at an odd count is ORed into the high half. Fetching continues while the remaining count is odd, and the word is then written to the destination address, which increases by 2.
- R7: With both sides 8-bit, each byte read is written as one byte (`mem_wdata[7:0]`), and the destination address increases by 1.
- R8: With a 16-bit source and an 8-bit destination, the low byte of the word is written first. The termination check comes next. If the transfer does not end, the high byte is written to the following address. So when the count reaches zero on a word, only that word's low byte is written.
- R9: With both sides 16-bit, each word read is written as one word, and the destination address increases by 2.
- R10: The termination field `cfg_tbc` must be nonzero, and the count must be zero at the check. The transfer then ends: the task pointer gains (`cfg_tbc` − 1) × 4, status bit 6 clears and status bit 2 sets.
- R11: Any of the following raises `fault` and halts the engine until reset, with no further memory requests and with `launch` ignored:
  - `cfg_port_mode`=1;
  - `cfg_sync`=1 (wait on the source) or `cfg_sync`=2 (wait on the destination);
  - `cfg_xlate`=1;
  - `cfg_cmp`≠0;
  - `cfg_term_ext` or `cfg_term_one` set at a check that does not end the transfer by count.
- R12: The status word has bit 0 = destination is 16-bit, bit 1 = source is 16-bit, bit 5 = bus load limit and bit 7 = priority, all latched at launch. Bits 3 and 4 read 0.
- R13: With an 8-bit source, a 16-bit destination and an odd starting count, the first byte goes to the high half over a zero low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start-transfer pulse |
| cfg_src16 | input | 1 | Source is 16 bits wide |
| cfg_dst16 | input | 1 | Destination is 16 bits wide |
| cfg_prio | input | 1 | Priority flag, reported in status bit 7 |
| cfg_blim | input | 1 | Bus load limit flag, reported in status bit 5 |
| cfg_port_mode | input | 1 | Port-mode transfer (unsupported) |
| cfg_sync | input | 2 | 1 = wait on source, 2 = wait on destination (unsupported); 0 or 3 = free running |
| cfg_xlate | input | 1 | Translation (unsupported) |
| cfg_cmp | input | 2 | Masked compare mode (unsupported if nonzero) |
| cfg_tbc | input | 2 | Byte-count termination; nonzero enables it and selects the offset |
| cfg_term_ext | input | 1 | External termination (unsupported) |
| cfg_term_one | input | 1 | Single-transfer termination (unsupported) |
| ld_src | input | ADDR_W | Initial source address |
| ld_dst | input | ADDR_W | Initial destination address |
| ld_cnt | input | CNT_W | Initial byte count |
| ld_tp | input | TP_W | Initial task pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = word access, 0 = byte access |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 16 | Write data (a byte uses bits 7:0) |
| mem_rdata | input | 16 | Read data (a byte uses bits 7:0), valid with mem_ready |
| status | output | 8 | Status word |
| xfer_pend | output | 1 | Transfer request pending |
| fault | output | 1 | Sticky unsupported-mode fault |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| byte_cnt | output | CNT_W | Current byte count |
| task_ptr | output | TP_W | Current task pointer |

## Verification
The status word and `xfer_pend` change at the clock edge that samples `launch`, so the bench reads them on the falling edge that follows. The clearing of status bit 2 is due one clock later and is read on the next falling edge. Each memory access completes at the rising edge where `mem_ready` is high. The bench drives `mem_ready` and commits writes on falling edges, so every write is recorded on the falling edge before the accepting edge. The final addresses, count, task pointer and memory image are compared once status bit 6 is seen low. By then the terminating check has taken effect, and the bench checks no intermediate cycle count.

// File: rtl/wadma_pkg.sv
package wadma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_WAIT_SRC = 4'd1,
    ST_FETCH    = 4'd2,
    ST_XLATE    = 4'd3,
    ST_WAIT_DST = 4'd4,
    ST_STORE    = 4'd5,
    ST_CMP      = 4'd6,
    ST_TERM     = 4'd7,
    ST_STORE_HI = 4'd8,
    ST_HALT     = 4'd9
  } wst_e;

  localparam int SB_DST16 = 0;
  localparam int SB_SRC16 = 1;
  localparam int SB_EXEC  = 2;
  localparam int SB_BLIM  = 5;
  localparam int SB_XFER  = 6;
  localparam int SB_PRIO  = 7;

  typedef struct packed {
    logic       port_mode;
    logic [1:0] sync;
    logic       xlate;
    logic [1:0] cmp;
    logic [1:0] tbc;
    logic       t_ext;
    logic       t_one;
    logic       src16;
    logic       dst16;
    logic       blim;
    logic       prio;
  } wcfg_t;

endpackage

// File: rtl/wadma_ctrl.sv
module wadma_ctrl
  import wadma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  wcfg_t cfg_in,
  input  logic  mem_ready,
  input  logic  cnt_zero,
  input  logic  cnt_lsb,
  output wst_e  state,
  output wcfg_t cfg_q,
  output logic  exec,
  output logic  xfer,
  output logic  pend,
  output logic  fault,
  output logic  want_mem,
  output logic  fire,
  output logic  term_hit,
  output logic  launch_ok
);

  wst_e nxt;
  logic set_fault;
  logic hi_sent;
  logic running;
  logic odd_after;

  assign running   = xfer & ~fault;
  assign launch_ok = launch & ~xfer & ~fault;
  assign want_mem  = running & ((state == ST_FETCH) || (state == ST_STORE) ||
                                (state == ST_STORE_HI));
  assign fire      = want_mem & mem_ready;
  assign term_hit  = running & (state == ST_TERM) & (cfg_q.tbc != 2'd0) & cnt_zero;
  assign odd_after = cfg_q.src16 ? cnt_lsb : ~cnt_lsb;

  always_comb begin
    nxt       = state;
    set_fault = 1'b0;
    if (running) begin
      unique case (state)
        ST_IDLE: begin
          if (cfg_q.port_mode) begin
            set_fault = 1'b1;
            nxt       = ST_HALT;
          end else if (cfg_q.sync == 2'd1) begin
            nxt = ST_WAIT_SRC;
          end else begin
            nxt = ST_FETCH;
          end
        end
        ST_WAIT_SRC, ST_WAIT_DST, ST_XLATE, ST_CMP: begin
          set_fault = 1'b1;
          nxt       = ST_HALT;
        end
        ST_FETCH: begin
          if (fire) begin
            if (cfg_q.dst16 && odd_after)   nxt = ST_FETCH;
            else if (cfg_q.xlate)           nxt = ST_XLATE;
            else if (cfg_q.sync == 2'd2)    nxt = ST_WAIT_DST;
            else                            nxt = ST_STORE;
          end
        end
        ST_STORE: begin
          if (fire) nxt = (cfg_q.cmp != 2'd0) ? ST_CMP : ST_TERM;
        end
        ST_TERM: begin
          if (term_hit) begin
            nxt = ST_IDLE;
          end else if (cfg_q.t_ext || cfg_q.t_one) begin
            set_fault = 1'b1;
            nxt       = ST_HALT;
          end else if (cfg_q.src16 && !cfg_q.dst16 && !hi_sent) begin
            nxt = ST_STORE_HI;
          end else begin
            nxt = ST_IDLE;
          end
        end
        ST_STORE_HI: begin
          if (fire) nxt = ST_TERM;
        end
        default: nxt = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cfg_q   <= '0;
      exec    <= 1'b0;
      xfer    <= 1'b0;
      pend    <= 1'b0;
      fault   <= 1'b0;
      hi_sent <= 1'b0;
    end else if (launch_ok) begin
      cfg_q   <= cfg_in;
      exec    <= 1'b1;
      xfer    <= 1'b1;
      pend    <= 1'b1;
      state   <= ST_IDLE;
      hi_sent <= 1'b0;
    end else begin
      if (running && exec) begin
        exec <= 1'b0;
        pend <= 1'b0;
      end
      state <= nxt;
      if (set_fault) fault <= 1'b1;
      if (term_hit) begin
        exec <= 1'b1;
        xfer <= 1'b0;
      end
      if (fire && state == ST_STORE_HI) hi_sent <= 1'b1;
      else if (state == ST_IDLE)        hi_sent <= 1'b0;
    end
  end

  // R3
  first_cycle_clears_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && exec && !fault) |=> !exec);

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R10
  end_returns_to_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer) |-> exec);

endmodule

// File: rtl/wadma_regs.sv
module wadma_regs
  import wadma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int TP_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_ok,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [TP_W-1:0]   ld_tp,
  input  wst_e              state,
  input  logic              fire,
  input  logic              term_hit,
  input  logic              src16,
  input  logic              dst16,
  input  logic [1:0]        tbc,
  input  logic [15:0]       mem_rdata,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [TP_W-1:0]   tp_q,
  output logic [15:0]       hold_q
);

  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TWO = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0]  C_TWO = CNT_W'(2);

  logic            do_fetch, do_store, do_store_hi;
  logic [1:0]      tbc_m1;
  logic [TP_W-1:0] tp_step;

  assign do_fetch    = fire && (state == ST_FETCH);
  assign do_store    = fire && (state == ST_STORE);
  assign do_store_hi = fire && (state == ST_STORE_HI);
  assign tbc_m1      = tbc - 2'd1;
  assign tp_step     = TP_W'({tbc_m1, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      tp_q   <= '0;
      hold_q <= '0;
    end else if (launch_ok) begin
      src_q  <= ld_src;
      dst_q  <= ld_dst;
      cnt_q  <= ld_cnt;
      tp_q   <= ld_tp;
      hold_q <= '0;
    end else begin
      if (do_fetch) begin
        if (src16) begin
          hold_q <= mem_rdata;
          src_q  <= src_q + A_TWO;
          cnt_q  <= cnt_q - C_TWO;
        end else begin
          if (dst16 && cnt_q[0]) hold_q[15:8] <= hold_q[15:8] | mem_rdata[7:0];
          else                   hold_q       <= {8'h00, mem_rdata[7:0]};
          src_q <= src_q + A_ONE;
          cnt_q <= cnt_q - C_ONE;
        end
      end
      if (do_store)    dst_q <= dst_q + (dst16 ? A_TWO : A_ONE);
      if (do_store_hi) dst_q <= dst_q + A_ONE;
      if (term_hit)    tp_q  <= tp_q + tp_step;
    end
  end

endmodule

// File: rtl/wadma_busport.sv
module wadma_busport
  import wadma_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wst_e              state,
  input  logic              want_mem,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [15:0]       hold_q,
  input  logic              src16,
  input  logic              dst16,
  output logic              mem_valid,
  output logic              mem_write,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata
);

  assign mem_valid = want_mem;

  always_comb begin
    mem_write = 1'b0;
    mem_wide  = src16;
    mem_addr  = src_q;
    mem_wdata = 16'h0000;
    if (state == ST_STORE) begin
      mem_write = 1'b1;
      mem_wide  = dst16;
      mem_addr  = dst_q;
      mem_wdata = dst16 ? hold_q : {8'h00, hold_q[7:0]};
    end else if (state == ST_STORE_HI) begin
      mem_write = 1'b1;
      mem_wide  = 1'b0;
      mem_addr  = dst_q;
      mem_wdata = {8'h00, hold_q[15:8]};
    end
  end

  // R4
  request_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
      $stable(mem_write) && $stable(mem_wide) && $stable(mem_wdata)));

endmodule

// File: rtl/wadma_channel.sv
module wadma_channel
  import wadma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int TP_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              cfg_src16,
  input  logic              cfg_dst16,
  input  logic              cfg_prio,
  input  logic              cfg_blim,
  input  logic              cfg_port_mode,
  input  logic [1:0]        cfg_sync,
  input  logic              cfg_xlate,
  input  logic [1:0]        cfg_cmp,
  input  logic [1:0]        cfg_tbc,
  input  logic              cfg_term_ext,
  input  logic              cfg_term_one,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [TP_W-1:0]   ld_tp,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic [7:0]        status,
  output logic              xfer_pend,
  output logic              fault,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [TP_W-1:0]   task_ptr
);

  wcfg_t cfg_in, cfg_q;
  wst_e  state;
  logic  exec, xfer, want_mem, fire, term_hit, launch_ok;
  logic [15:0] hold_q;

  assign cfg_in = '{port_mode: cfg_port_mode, sync: cfg_sync, xlate: cfg_xlate,
                    cmp: cfg_cmp, tbc: cfg_tbc, t_ext: cfg_term_ext,
                    t_one: cfg_term_one, src16: cfg_src16, dst16: cfg_dst16,
                    blim: cfg_blim, prio: cfg_prio};

  wadma_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .cfg_in    (cfg_in),
    .mem_ready (mem_ready),
    .cnt_zero  (byte_cnt == '0),
    .cnt_lsb   (byte_cnt[0]),
    .state     (state),
    .cfg_q     (cfg_q),
    .exec      (exec),
    .xfer      (xfer),
    .pend      (xfer_pend),
    .fault     (fault),
    .want_mem  (want_mem),
    .fire      (fire),
    .term_hit  (term_hit),
    .launch_ok (launch_ok)
  );

  wadma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TP_W(TP_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_ok (launch_ok),
    .ld_src    (ld_src),
    .ld_dst    (ld_dst),
    .ld_cnt    (ld_cnt),
    .ld_tp     (ld_tp),
    .state     (state),
    .fire      (fire),
    .term_hit  (term_hit),
    .src16     (cfg_q.src16),
    .dst16     (cfg_q.dst16),
    .tbc       (cfg_q.tbc),
    .mem_rdata (mem_rdata),
    .src_q     (src_addr),
    .dst_q     (dst_addr),
    .cnt_q     (byte_cnt),
    .tp_q      (task_ptr),
    .hold_q    (hold_q)
  );

  wadma_busport #(.ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .want_mem  (want_mem),
    .mem_ready (mem_ready),
    .src_q     (src_addr),
    .dst_q     (dst_addr),
    .hold_q    (hold_q),
    .src16     (cfg_q.src16),
    .dst16     (cfg_q.dst16),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_comb begin
    status           = 8'h00;
    status[SB_DST16] = cfg_q.dst16;
    status[SB_SRC16] = cfg_q.src16;
    status[SB_EXEC]  = exec;
    status[SB_BLIM]  = cfg_q.blim;
    status[SB_XFER]  = xfer;
    status[SB_PRIO]  = cfg_q.prio;
  end

  // R5
  wide_fetch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write && mem_wide) |=>
      (byte_cnt == $past(byte_cnt) - CNT_W'(2)));

  // R10
  end_at_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status[SB_XFER]) && !fault) |-> (byte_cnt == '0));

  // R11
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> !mem_valid);

endmodule

// File: tb/tb_wadma_channel.sv
`timescale 1ns/1ps
module tb_wadma_channel;
  localparam int AW = 20;
  localparam int CW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, launch;
  logic c_src16, c_dst16, c_prio, c_blim, c_port, c_xlate, c_ext, c_one;
  logic [1:0] c_sync, c_cmp, c_tbc;
  logic [AW-1:0] l_src, l_dst;
  logic [CW-1:0] l_cnt;
  logic [TW-1:0] l_tp;
  logic mem_valid, mem_ready, mem_write, mem_wide;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0] status;
  logic xfer_pend, fault;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] byte_cnt;
  logic [TW-1:0] task_ptr;

  wadma_channel #(.ADDR_W(AW), .CNT_W(CW), .TP_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .cfg_src16(c_src16), .cfg_dst16(c_dst16), .cfg_prio(c_prio), .cfg_blim(c_blim),
    .cfg_port_mode(c_port), .cfg_sync(c_sync), .cfg_xlate(c_xlate), .cfg_cmp(c_cmp),
    .cfg_tbc(c_tbc), .cfg_term_ext(c_ext), .cfg_term_one(c_one),
    .ld_src(l_src), .ld_dst(l_dst), .ld_cnt(l_cnt), .ld_tp(l_tp),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .status(status), .xfer_pend(xfer_pend), .fault(fault),
    .src_addr(src_addr), .dst_addr(dst_addr), .byte_cnt(byte_cnt), .task_ptr(task_ptr)
  );

  logic [7:0] mem [1024];
  logic [7:0] expm [1024];
  logic [9:0] ra0, ra1;
  assign ra0 = mem_addr[9:0];
  assign ra1 = ra0 + 10'd1;
  assign mem_rdata = mem_wide ? {mem[ra1], mem[ra0]} : {8'h00, mem[ra0]};

  int rdy_mode = 1;
  int wr_count = 0;
  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(negedge clk) begin : responder
    logic r;
    case (rdy_mode)
      0: r = (($urandom % 3) != 0);
      1: r = 1'b1;
      default: r = 1'b0;
    endcase
    if (mem_valid && mem_write && r) begin
      mem[ra0] = mem_wdata[7:0];
      if (mem_wide) mem[ra1] = mem_wdata[15:8];
      wr_count++;
    end
    mem_ready <= r;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_cfg();
    launch = 0; c_src16 = 0; c_dst16 = 0; c_prio = 0; c_blim = 0; c_port = 0;
    c_xlate = 0; c_ext = 0; c_one = 0; c_sync = 0; c_cmp = 0; c_tbc = 1;
    l_src = '0; l_dst = '0; l_cnt = '0; l_tp = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    clear_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic start(input bit s16, input bit d16, input int n, input int s,
                       input int d, input int tp, input logic [1:0] tbc);
    c_src16 = s16; c_dst16 = d16; c_tbc = tbc;
    l_src = AW'(s); l_dst = AW'(d); l_cnt = CW'(n); l_tp = TW'(tp);
    launch = 1;
    @(negedge clk);
    launch = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (status[6] && !fault && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(!status[6] && !fault, req, "transfer end", {status[6], fault}, 0);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'($urandom);
      expm[i] = mem[i];
    end
  endtask

  function automatic int exp_dst_end(bit s16, bit d16, int n, int d);
    if (s16 && !d16) return d + n - 1;
    if (!s16 && d16 && (n % 2 == 1)) return d + n + 1;
    return d + n;
  endfunction

  task automatic model_copy(bit s16, bit d16, int n, int s, int d);
    if (s16 && !d16) begin
      for (int i = 0; i < n - 1; i++) expm[d + i] = mem[s + i];
    end else if (!s16 && d16 && (n % 2 == 1)) begin
      expm[d] = 8'h00;
      for (int i = 0; i < n; i++) expm[d + 1 + i] = mem[s + i];
    end else begin
      for (int i = 0; i < n; i++) expm[d + i] = mem[s + i];
    end
  endtask

  task automatic run_xfer(bit s16, bit d16, int n, int s, int d, int tp,
                          logic [1:0] tbc);
    int bad = 0;
    string req;
    fill_mem();
    model_copy(s16, d16, n, s, d);
    start(s16, d16, n, s, d, tp, tbc);
    wait_idle("R10");
    for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) bad++;
    if (s16 && d16)            req = "R9";
    else if (s16)              req = "R8";
    else if (!d16)             req = "R7";
    else if (n % 2 == 1)       req = "R13";
    else                       req = "R6";
    chk(bad == 0, req, "memory mismatches", bad, 0);
    chk(src_addr == AW'(s + n), s16 ? "R5" : "R6", "source address", src_addr, s + n);
    chk(dst_addr == AW'(exp_dst_end(s16, d16, n, d)), req, "destination address",
        dst_addr, exp_dst_end(s16, d16, n, d));
    chk(byte_cnt == 0, "R10", "byte count", byte_cnt, 0);
    chk(task_ptr == TW'(tp + (int'(tbc) - 1) * 4), "R10", "task pointer",
        task_ptr, TW'(tp + (int'(tbc) - 1) * 4));
    chk(status == {c_prio, 1'b0, c_blim, 2'b00, 1'b1, s16, d16}, "R12", "status word",
        status, {c_prio, 1'b0, c_blim, 2'b00, 1'b1, s16, d16});
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 0;
    clear_cfg();
    do_reset();

    // R1 reset state
    chk(status == 8'h00, "R1", "status after reset", status, 0);
    chk(!fault && !xfer_pend && !mem_valid, "R1", "fault/pend/valid after reset",
        {fault, xfer_pend, mem_valid}, 0);

    // R2 R3 R12 launch flags, then an 8-bit to 8-bit copy
    rdy_mode = 1;
    fill_mem();
    model_copy(0, 0, 3, 16, 600);
    c_prio = 1; c_blim = 1;
    start(0, 0, 3, 16, 600, 16'h0100, 2'd1);
    chk(status == 8'hE4, "R2", "status after launch", status, 8'hE4);
    chk(xfer_pend == 1'b1, "R2", "pending after launch", xfer_pend, 1);
    @(negedge clk);
    chk(status == 8'hE0, "R3", "status after first active cycle", status, 8'hE0);
    chk(xfer_pend == 1'b0, "R3", "pending after first active cycle", xfer_pend, 0);
    wait_idle("R7");
    begin
      int bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) bad++;
      chk(bad == 0, "R7", "byte copy memory", bad, 0);
    end
    chk(task_ptr == 16'h0100, "R10", "task pointer with field 1", task_ptr, 16'h0100);
    c_prio = 0; c_blim = 0;

    // R4 back-pressure and R2 ignored relaunch
    fill_mem();
    model_copy(1, 1, 4, 40, 700);
    rdy_mode = 2;
    start(1, 1, 4, 40, 700, 0, 2'd2);
    repeat (2) @(negedge clk);
    l_src = AW'(200); l_dst = AW'(900); l_cnt = CW'(8); c_src16 = 0;
    launch = 1;
    @(negedge clk);
    launch = 0;
    c_src16 = 1;
    begin
      int bad = 0;
      for (int k = 0; k < 6; k++) begin
        if (!(mem_valid && !mem_write && mem_wide && mem_addr == AW'(40))) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R4", "held request cycles wrong", bad, 0);
    end
    chk(src_addr == AW'(40), "R2", "source after ignored launch", src_addr, 40);
    rdy_mode = 1;
    wait_idle("R4");
    begin
      int bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) bad++;
      chk(bad == 0, "R9", "word copy after stall", bad, 0);
    end
    chk(dst_addr == AW'(704), "R9", "destination after stall", dst_addr, 704);
    chk(task_ptr == 16'h0004, "R10", "task pointer with field 2", task_ptr, 4);

    // directed corners
    run_xfer(1, 0, 2, 10, 520, 16'h0020, 2'd3);   // R8 single word, low byte only
    run_xfer(1, 0, 6, 10, 520, 16'h0020, 2'd1);   // R8 split words
    run_xfer(0, 1, 5, 11, 530, 16'h0000, 2'd2);   // R13 odd start
    run_xfer(0, 1, 4, 11, 530, 16'h0000, 2'd2);   // R6 even pack

    // constrained random over all width pairs
    rdy_mode = 0;
    for (int it = 0; it < 48; it++) begin
      bit s16 = 1'($urandom);
      bit d16 = 1'($urandom);
      int n = 1 + int'($urandom % 14);
      logic [1:0] tbc = 2'(1 + ($urandom % 3));
      if (s16) n = 2 * (1 + int'($urandom % 7));
      c_prio = 1'($urandom);
      c_blim = 1'($urandom);
      run_xfer(s16, d16, n, int'($urandom % 200), 512 + int'($urandom % 200),
               int'($urandom % 65536), tbc);
    end
    rdy_mode = 1;

    // R11 unsupported settings
    for (int m = 0; m < 7; m++) begin
      do_reset();
      wr_count = 0;
      case (m)
        0: c_port = 1;
        1: c_sync = 2'd1;
        2: c_sync = 2'd2;
        3: c_xlate = 1;
        4: c_cmp = 2'd1;
        5: c_ext = 1;
        default: c_one = 1;
      endcase
      start(0, 0, 4, 20, 600, 0, 2'd1);
      repeat (20) @(negedge clk);
      chk(fault == 1'b1, "R11", $sformatf("fault for setting %0d", m), fault, 1);
      l_src = AW'(300);
      launch = 1;
      @(negedge clk);
      launch = 0;
      begin
        int bad = 0;
        for (int k = 0; k < 5; k++) begin
          if (mem_valid) bad++;
          @(negedge clk);
        end
        chk(bad == 0, "R11", "requests while halted", bad, 0);
      end
      chk(src_addr != AW'(300), "R11", "launch accepted while halted", src_addr, 300);
      if (m <= 3) chk(wr_count == 0, "R11", "writes before halt", wr_count, 0);
    end

    do_reset();
    chk(!fault && status == 8'h00, "R1", "reset clears fault", {fault, status}, 0);
    summary();
  end
endmodule